// File: doc/BRIEF.md
# Address-masked GPIO data port

This block is the data path of one general-purpose I/O port of eight pins. One access can set, clear or sample any subset of pins without a read-modify-write sequence. The word address of a data access carries a per-pin mask in bits [9:2]. Bits [1:0] select a byte within the word and play no part. The data register therefore fills a window of 256 words, and the mask is chosen by which word in that window is accessed.

A write updates only the output bits whose mask bit is set. All other output bits keep their value. A read returns zero for unselected pins. Each selected pin returns one of two values. A pin configured as an output returns its output register bit. A pin configured as an input returns its pad level, taken through a two-stage synchroniser. The all-ones mask reaches the whole port at once. Inverting pins is not atomic: software reads the pins under a mask, then writes the inverted value under the same mask.

Top module: `gpio_mask_port`

## Requirements
- R1: While rst_ni is low and after its release, dout_o and rdata_o are 0 until the first write or read.
- R2: When we_i is high at a clock edge, every pin n with addr_i[2+n]=1 takes wdata_i[n] in dout_o from that edge on, and every pin with addr_i[2+n]=0 keeps its previous dout_o value.
- R3: A write whose mask addr_i[9:2] is 0x00 leaves dout_o unchanged whatever wdata_i holds.
- R4: When re_i is high at a clock edge, rdata_o is updated at that edge, and bits whose mask bit addr_i[2+n] is 0 read as 0. While re_i is low, rdata_o holds its last value.
- R5: A selected pin with dir_i[n]=1 (output) reads its dout_o bit. A selected pin with dir_i[n]=0 (input) reads its synchronised pad level.
- R6: A pad_i change set up before clock edge E1 is returned by a read sampled at edge E3. Reads sampled at E1 and E2 still return the old level.
- R7: addr_i[1:0] has no effect on writes or reads.
- R8: A mask of 0xFF writes all eight output bits, and a read with that mask returns all eight pins.
- R9: A read and a write at the same edge return the output register value from before that write.
- R10: With we_i low, wdata_i and addr_i have no effect on dout_o.
- R11: A toggle done as a masked read followed by a masked write of the inverted read data inverts exactly the selected output pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 10 | Word address. Bits [9:2] are the pin mask and bits [1:0] are ignored |
| wdata_i | input | 8 | Write data, one bit per pin |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| pad_i | input | 8 | Pad input levels, asynchronous |
| dir_i | input | 8 | Pin direction, 1 = output, 0 = input |
| rdata_o | output | 8 | Masked read data, registered |
| dout_o | output | 8 | Output data register |

## Verification
A corrupted output register bit appears on dout_o at the edge after the faulty write. A fault in the mask merge, such as an unselected bit taking write data, shows up the same way. A wrong direction select or a wrong mask on the read side shows in rdata_o one cycle after the read strobe. This holds for the pin levels chosen in the vectors, which differ between the output register and the pad. A synchroniser with the wrong depth shifts the first read that returns a new pad level by one cycle. The bench therefore samples reads at the edge before the new level is due, at the edge it is due, and at the edge after.

// File: rtl/gpio_mask_pkg.sv
`timescale 1ns/1ps
package gpio_mask_pkg;
  // Lowest address bit of the per-pin mask field
  localparam int unsigned MASK_LSB = 2;

  typedef enum logic {
    PIN_IN  = 1'b0,
    PIN_OUT = 1'b1
  } pin_dir_e;
endpackage

// File: rtl/gpio_mask_sync.sv
`timescale 1ns/1ps
module gpio_mask_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

  // R6: first stage captures the pad, later stages shift by one edge each
  p_first_stage_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> stage_q[0] == $past(d_i));
  p_last_stage_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> q_o == $past(stage_q[STAGES-2]));
endmodule

// File: rtl/gpio_mask_out.sv
`timescale 1ns/1ps
module gpio_mask_out #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q;

  for (genvar n = 0; n < WIDTH; n++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                q_q[n] <= 1'b0;
      else if (we_i && mask_i[n]) q_q[n] <= wdata_i[n];
    end
  end

  assign q_o = q_q;

  // R2: unselected bits keep their value across a write
  p_hold_unsel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((q_o ^ $past(q_o)) & ~$past(mask_i)) == '0);
  // R2: selected bits carry the written data
  p_take_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((q_o ^ $past(wdata_i)) & $past(mask_i)) == '0);
  // R10: no strobe, no change
  p_no_we_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/gpio_mask_rd.sv
`timescale 1ns/1ps
module gpio_mask_rd
  import gpio_mask_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             re_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] out_i,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] pin_val;
  logic [WIDTH-1:0] rd_q;

  for (genvar n = 0; n < WIDTH; n++) begin : g_pin
    always_comb begin
      unique case (pin_dir_e'(dir_i[n]))
        PIN_OUT: pin_val[n] = out_i[n];
        default: pin_val[n] = pad_i[n];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (re_i) rd_q <= pin_val & mask_i;
  end

  assign rdata_o = rd_q;

  // R4: unselected bits read zero
  p_rd_unsel_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |=> (rdata_o & ~$past(mask_i)) == '0);
  // R4: read data holds without a strobe
  p_rd_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
  // R5: selected output pins return the output register
  p_rd_out_pin_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |=> ((rdata_o ^ $past(out_i)) & $past(mask_i & dir_i)) == '0);
endmodule

// File: rtl/gpio_mask_port.sv
`timescale 1ns/1ps
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W     = MASK_LSB + NUM_PINS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  input  logic                we_i,
  input  logic                re_i,
  input  logic [NUM_PINS-1:0] pad_i,
  input  logic [NUM_PINS-1:0] dir_i,
  output logic [NUM_PINS-1:0] rdata_o,
  output logic [NUM_PINS-1:0] dout_o
);
  logic [NUM_PINS-1:0] pin_mask;
  logic [NUM_PINS-1:0] pad_sync;
  logic [MASK_LSB-1:0] unused_byte_sel;

  assign pin_mask        = addr_i[ADDR_W-1:MASK_LSB];
  assign unused_byte_sel = addr_i[MASK_LSB-1:0]; // R7: byte select ignored

  gpio_mask_sync #(
    .WIDTH (NUM_PINS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (pad_sync)
  );

  gpio_mask_out #(
    .WIDTH(NUM_PINS)
  ) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .mask_i (pin_mask),
    .wdata_i(wdata_i),
    .q_o    (dout_o)
  );

  // Reads see dout_o before a same-edge write lands (R9)
  gpio_mask_rd #(
    .WIDTH(NUM_PINS)
  ) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .re_i   (re_i),
    .mask_i (pin_mask),
    .dir_i  (dir_i),
    .out_i  (dout_o),
    .pad_i  (pad_sync),
    .rdata_o(rdata_o)
  );

  // R3: an empty mask write leaves the port untouched
  p_empty_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && pin_mask == '0) |=> $stable(dout_o));
  // R9: read concurrent with write returns pre-write output bits
  p_rd_during_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && re_i) |=> ((rdata_o ^ $past(dout_o)) & $past(pin_mask & dir_i)) == '0);
endmodule

// File: tb/sim_gpio_mask_port.sv
`timescale 1ns/1ps
module sim_gpio_mask_port;
  localparam int NP = 8;
  localparam int AW = NP + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NP-1:0] wdata = '0;
  logic          we = 1'b0;
  logic          re = 1'b0;
  logic [NP-1:0] pad = '0;
  logic [NP-1:0] dir = '0;
  logic [NP-1:0] rdata;
  logic [NP-1:0] dout;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_mask_port u0 (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .addr_i (addr),
    .wdata_i(wdata),
    .we_i   (we),
    .re_i   (re),
    .pad_i  (pad),
    .dir_i  (dir),
    .rdata_o(rdata),
    .dout_o (dout)
  );

  // {wmask, wdata, rmask, dir, pad, exp_dout, exp_rdata}
  typedef struct packed {
    logic [7:0] wmask;
    logic [7:0] wd;
    logic [7:0] rmask;
    logic [7:0] dr;
    logic [7:0] pd;
    logic [7:0] exp_out;
    logic [7:0] exp_rd;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'hFF, 8'hA5, 8'hFF, 8'hFF, 8'h00, 8'hA5, 8'hA5}, // R8 full port
    '{8'h0F, 8'h3C, 8'hF0, 8'hFF, 8'h00, 8'hAC, 8'hA0}, // R2 low nibble
    '{8'h00, 8'hFF, 8'hFF, 8'h00, 8'h5A, 8'hAC, 8'h5A}, // R3 empty mask
    '{8'h81, 8'h00, 8'hFF, 8'hF0, 8'h0F, 8'h2C, 8'h2F}, // R5 mixed dir
    '{8'h3C, 8'hFF, 8'h0F, 8'h0F, 8'hF0, 8'h3C, 8'h0C}, // R4 partial read
    '{8'hC3, 8'h42, 8'h99, 8'hAA, 8'h55, 8'h7E, 8'h19}, // R5 interleaved
    '{8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00}, // R8 clear all
    '{8'h55, 8'hFF, 8'hAA, 8'h00, 8'hFF, 8'h55, 8'hAA}  // R4 pad read
  };

  task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle starting and ending at a falling edge
  task automatic bus(input logic w, input logic r, input logic [7:0] m,
                     input logic [1:0] lo, input logic [NP-1:0] d);
    addr  = {m, lo};
    wdata = d;
    we    = w;
    re    = r;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
    re = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [NP-1:0] snap;
    idle(2);
    check("R1 dout in reset", dout, 8'h00);
    check("R1 rdata in reset", rdata, 8'h00);
    rst_n = 1'b1;
    idle(2);
    check("R1 dout after reset", dout, 8'h00);
    check("R1 rdata after reset", rdata, 8'h00);

    for (int v = 0; v < 8; v++) begin
      dir = VECS[v].dr;
      pad = VECS[v].pd;
      idle(3);
      bus(1'b1, 1'b0, VECS[v].wmask, 2'b00, VECS[v].wd);
      check($sformatf("R2 vector %0d dout", v), dout, VECS[v].exp_out);
      bus(1'b0, 1'b1, VECS[v].rmask, 2'b00, 8'h00);
      check($sformatf("R5 vector %0d rdata", v), rdata, VECS[v].exp_rd);
    end

    // R7: byte select bits ignored (dout is 0x55)
    bus(1'b1, 1'b0, 8'h0F, 2'b11, 8'h09);
    check("R7 write with addr[1:0]=3", dout, 8'h59);
    dir = 8'hFF;
    bus(1'b0, 1'b1, 8'hF0, 2'b10, 8'h00);
    check("R7 read with addr[1:0]=2", rdata, 8'h50);

    // R10: no strobe, no change
    addr = {8'hFF, 2'b00}; wdata = 8'hC3; we = 1'b0;
    idle(2);
    check("R10 dout without we", dout, 8'h59);

    // R4: rdata holds while re is low
    bus(1'b1, 1'b0, 8'hFF, 2'b00, 8'h66);
    check("R4 rdata held", rdata, 8'h50);

    // R9: read and write at the same edge
    bus(1'b1, 1'b1, 8'hFF, 2'b00, 8'h11);
    check("R9 rdata pre-write", rdata, 8'h66);
    check("R9 dout post-write", dout, 8'h11);

    // R11: toggle pins 0..3 by read then inverted write
    bus(1'b0, 1'b1, 8'h0F, 2'b00, 8'h00);
    snap = rdata;
    bus(1'b1, 1'b0, 8'h0F, 2'b00, ~snap);
    check("R11 toggle low nibble", dout, 8'h1E);

    // R6: pad latency through synchroniser
    dir = 8'h00;
    pad = 8'h00;
    idle(3);
    pad = 8'hC6;
    bus(1'b0, 1'b1, 8'hFF, 2'b00, 8'h00);
    check("R6 read at E1 old", rdata, 8'h00);
    bus(1'b0, 1'b1, 8'hFF, 2'b00, 8'h00);
    check("R6 read at E2 old", rdata, 8'h00);
    bus(1'b0, 1'b1, 8'hFF, 2'b00, 8'h00);
    check("R6 read at E3 new", rdata, 8'hC6);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule